// File: doc/BRIEF.md
# SMBus Host Block Transfer Staging Buffer

This block sits between the CPU register interface of an SMBus host controller and its serial byte engine. It holds the bytes of a block read or block write transaction in a small array. The CPU reaches the array through one data register with an index that steps by itself. The block also keeps the byte-count register and the transaction control and status registers. It decides whether a start command may launch the engine.

Before a block write, software fills the array one byte at a time and writes the count. It then sets the start bit. The engine fetches bytes from entry 0 upward. During a block read, the engine stores each received byte from entry 0 upward. When it finishes, it reports how many bytes the remote device sent, and that number replaces the count register. A new start is refused until software has acknowledged the previous result by clearing the completion flags. The engine rewrites the array and the count while it runs, so values that software still needs must be copied out before it issues a start.

Top module: `smb_blkbuf`

## Requirements
- R1: After reset every register reads 0, both array pointers are 0, all array entries are 0 and the block is idle.
- R2: A CPU read of the control register (address 1) sets the CPU array index to 0.
- R3: Each CPU read or write of the block data register (address 3) accesses the entry at the CPU index and then advances the index by one, wrapping from 31 to 0.
- R4: The status register (address 0) reads bit0 busy, bit1 done, bit2 error. Writing 1 to bit1 or bit2 clears that flag. A flag being set by the engine in the same cycle as a clear stays set.
- R5: A control write latches bit0 as the mode (1 = block write, 0 = block read) only while idle. A write with bit6 set that is accepted sets busy and, one cycle later, gives a one-cycle `eng_start` pulse, with `eng_wr_mode` showing the mode.
- R6: At start the engine index is 0. `eng_tx_byte` shows the entry at the engine index, and each `eng_tx_take` while busy advances the engine index with wrap.
- R7: A start request is ignored, with no pulse and no busy, while busy or while the done or error flag is set.
- R8: While busy, `eng_rx_valid` stores `eng_rx_byte` at the engine index and advances it.
- R9: `eng_done` while busy clears busy and sets done, or sets error when `eng_err` is high.
- R10: At completion of a block read, the count register takes `eng_rx_count`. A block write leaves the count register unchanged.
- R11: CPU writes to the block data register while busy leave the array unchanged, but the CPU index still advances.
- R12: The count register (address 2) is read and written by the CPU and drives `eng_count`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_addr | input | 2 | Register select: 0 status, 1 control, 2 count, 3 block data |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data of the selected register |
| eng_start | output | 1 | One-cycle launch pulse to the engine |
| eng_wr_mode | output | 1 | 1 = block write, 0 = block read |
| eng_count | output | 8 | Byte count for a block write |
| eng_tx_byte | output | 8 | Array byte at the engine index |
| eng_tx_take | input | 1 | Engine consumed `eng_tx_byte` |
| eng_rx_valid | input | 1 | Engine delivers a received byte |
| eng_rx_byte | input | 8 | Received byte |
| eng_done | input | 1 | Transaction finished |
| eng_err | input | 1 | Finished with an error |
| eng_rx_count | input | 8 | Bytes received in a block read |

## Verification
The bench builds the block with its default depth of 32 bytes and 8-bit data. At that depth, a 33rd consecutive data-register write is enough to show the index wrapping back to entry 0 and overwriting it. The small depth also lets a full write-then-read-back pass run in a few hundred cycles. These values reach every ordering that matters: start refused by a stale flag, a CPU write landing during a transaction, and a flag clear colliding with completion.

// File: rtl/smb_blkbuf_pkg.sv
package smb_blkbuf_pkg;

  typedef enum logic [1:0] {
    REG_STAT = 2'd0,
    REG_CTRL = 2'd1,
    REG_CNT  = 2'd2,
    REG_BLK  = 2'd3
  } reg_sel_e;

  localparam int ST_BUSY  = 0;
  localparam int ST_DONE  = 1;
  localparam int ST_ERR   = 2;
  localparam int CT_MODE  = 0;
  localparam int CT_START = 6;

  // next index value in a ring of 'depth' entries
  function automatic int unsigned ring_next(input int unsigned cur, input int unsigned depth);
    return (cur + 1 >= depth) ? 0 : cur + 1;
  endfunction

endpackage

// File: rtl/smb_blkbuf_ptr.sv
module smb_blkbuf_ptr #(
  parameter int DEPTH = 32,
  parameter int IW    = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          adv,
  output logic [IW-1:0] ptr
);
  import smb_blkbuf_pkg::*;

  logic [IW-1:0] ptr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   ptr_q <= '0;
    else if (clr) ptr_q <= '0;
    else if (adv) ptr_q <= IW'(ring_next(32'(ptr_q), DEPTH));
  end

  assign ptr = ptr_q;
endmodule

// File: rtl/smb_blkbuf_mem.sv
module smb_blkbuf_mem #(
  parameter int DEPTH = 32,
  parameter int DW    = 8,
  parameter int IW    = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [IW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [IW-1:0] raddr_a,
  output logic [DW-1:0] rdata_a,
  input  logic [IW-1:0] raddr_b,
  output logic [DW-1:0] rdata_b
);
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we) begin
      mem_q[waddr] <= wdata;
    end
  end

  assign rdata_a = mem_q[raddr_a];
  assign rdata_b = mem_q[raddr_b];
endmodule

// File: rtl/smb_blkbuf_ctl.sv
module smb_blkbuf_ctl #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctrl_wr,
  input  logic          stat_wr,
  input  logic          cnt_wr,
  input  logic [DW-1:0] wdata,
  input  logic          eng_done,
  input  logic          eng_err,
  input  logic [DW-1:0] eng_rx_count,
  output logic          busy,
  output logic          done_flag,
  output logic          err_flag,
  output logic          mode,
  output logic [DW-1:0] count,
  output logic          start_req,
  output logic          start_acc,
  output logic          eng_start
);
  import smb_blkbuf_pkg::*;

  logic          busy_q, done_q, err_q, mode_q, start_q;
  logic [DW-1:0] count_q;
  logic          finish, done_set, err_set, done_clr, err_clr;

  assign start_req = ctrl_wr && wdata[CT_START];
  assign start_acc = start_req && !busy_q && !done_q && !err_q;
  assign finish    = busy_q && eng_done;
  assign done_set  = finish && !eng_err;
  assign err_set   = finish && eng_err;
  assign done_clr  = stat_wr && wdata[ST_DONE];
  assign err_clr   = stat_wr && wdata[ST_ERR];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      mode_q  <= 1'b0;
      start_q <= 1'b0;
      count_q <= '0;
    end else begin
      start_q <= start_acc;
      if (start_acc)   busy_q <= 1'b1;
      else if (finish) busy_q <= 1'b0;
      done_q <= done_set | (done_q & ~done_clr);
      err_q  <= err_set  | (err_q  & ~err_clr);
      if (ctrl_wr && !busy_q) mode_q <= wdata[CT_MODE];
      if (finish && !mode_q)  count_q <= eng_rx_count;
      else if (cnt_wr)        count_q <= wdata;
    end
  end

  assign busy      = busy_q;
  assign done_flag = done_q;
  assign err_flag  = err_q;
  assign mode      = mode_q;
  assign count     = count_q;
  assign eng_start = start_q;
endmodule

// File: rtl/smb_blkbuf.sv
module smb_blkbuf #(
  parameter int DEPTH = 32,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    reg_addr,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          eng_start,
  output logic          eng_wr_mode,
  output logic [DW-1:0] eng_count,
  output logic [DW-1:0] eng_tx_byte,
  input  logic          eng_tx_take,
  input  logic          eng_rx_valid,
  input  logic [DW-1:0] eng_rx_byte,
  input  logic          eng_done,
  input  logic          eng_err,
  input  logic [DW-1:0] eng_rx_count
);
  import smb_blkbuf_pkg::*;

  localparam int IW = $clog2(DEPTH);

  reg_sel_e      sel;
  logic          ctrl_rd, ctrl_wr, stat_wr, cnt_wr, blk_access, blk_wr;
  logic          busy, done_flag, err_flag, mode, start_req, start_acc;
  logic          cpu_mem_we, eng_mem_we, mem_we, eng_adv, flags_any;
  logic [IW-1:0] cpu_ptr, eng_ptr, mem_waddr;
  logic [DW-1:0] count, cpu_byte, mem_wdata;

  assign sel        = reg_sel_e'(reg_addr);
  assign ctrl_rd    = reg_rd && (sel == REG_CTRL);
  assign ctrl_wr    = reg_wr && (sel == REG_CTRL);
  assign stat_wr    = reg_wr && (sel == REG_STAT);
  assign cnt_wr     = reg_wr && (sel == REG_CNT);
  assign blk_access = (reg_rd || reg_wr) && (sel == REG_BLK);
  assign blk_wr     = reg_wr && (sel == REG_BLK);
  assign flags_any  = done_flag || err_flag;

  // one write port: CPU owns it while idle, engine while busy
  assign cpu_mem_we = blk_wr && !busy;
  assign eng_mem_we = eng_rx_valid && busy;
  assign mem_we     = cpu_mem_we || eng_mem_we;
  assign mem_waddr  = busy ? eng_ptr : cpu_ptr;
  assign mem_wdata  = busy ? eng_rx_byte : reg_wdata;
  assign eng_adv    = busy && (eng_tx_take || eng_rx_valid);

  smb_blkbuf_ctl #(.DW(DW)) u_ctl (
    .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .stat_wr(stat_wr), .cnt_wr(cnt_wr),
    .wdata(reg_wdata), .eng_done(eng_done), .eng_err(eng_err),
    .eng_rx_count(eng_rx_count), .busy(busy), .done_flag(done_flag),
    .err_flag(err_flag), .mode(mode), .count(count), .start_req(start_req),
    .start_acc(start_acc), .eng_start(eng_start)
  );

  smb_blkbuf_ptr #(.DEPTH(DEPTH), .IW(IW)) u_cpu_ptr (
    .clk(clk), .rst_n(rst_n), .clr(ctrl_rd), .adv(blk_access), .ptr(cpu_ptr)
  );

  smb_blkbuf_ptr #(.DEPTH(DEPTH), .IW(IW)) u_eng_ptr (
    .clk(clk), .rst_n(rst_n), .clr(start_acc), .adv(eng_adv), .ptr(eng_ptr)
  );

  smb_blkbuf_mem #(.DEPTH(DEPTH), .DW(DW), .IW(IW)) u_mem (
    .clk(clk), .rst_n(rst_n), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .raddr_a(cpu_ptr), .rdata_a(cpu_byte), .raddr_b(eng_ptr), .rdata_b(eng_tx_byte)
  );

  always_comb begin
    reg_rdata = '0;
    unique case (sel)
      REG_STAT: begin
        reg_rdata[ST_BUSY] = busy;
        reg_rdata[ST_DONE] = done_flag;
        reg_rdata[ST_ERR]  = err_flag;
      end
      REG_CTRL: reg_rdata[CT_MODE] = mode;
      REG_CNT:  reg_rdata = count;
      REG_BLK:  reg_rdata = cpu_byte;
    endcase
  end

  assign eng_wr_mode = mode;
  assign eng_count   = count;
endmodule

// File: rtl/smb_blkbuf_chk.sv
module smb_blkbuf_chk #(
  parameter int DEPTH = 32,
  parameter int IW    = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ctrl_rd,
  input logic          blk_access,
  input logic          start_req,
  input logic          flags_any,
  input logic          busy,
  input logic          eng_start,
  input logic          eng_done,
  input logic          done_flag,
  input logic          err_flag,
  input logic [IW-1:0] cpu_ptr,
  input logic [IW-1:0] eng_ptr
);

  a_r2_ctrl_read_rewinds: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_rd |=> (cpu_ptr == '0));

  a_r3_access_steps: assert property (@(posedge clk) disable iff (!rst_n)
    blk_access |=> (($past(cpu_ptr) == IW'(DEPTH - 1)) ? (cpu_ptr == '0)
                                                      : (cpu_ptr == $past(cpu_ptr) + 1'b1)));

  a_r7_start_refused: assert property (@(posedge clk) disable iff (!rst_n)
    (start_req && (flags_any || busy)) |=> !eng_start);

  a_r6_engine_from_zero: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |-> (busy && eng_ptr == '0));

  a_r9_done_releases: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && eng_done) |=> (!busy && (done_flag != err_flag)));

endmodule

bind smb_blkbuf smb_blkbuf_chk #(.DEPTH(DEPTH), .IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ctrl_rd(ctrl_rd), .blk_access(blk_access),
  .start_req(start_req), .flags_any(flags_any), .busy(busy), .eng_start(eng_start),
  .eng_done(eng_done), .done_flag(done_flag), .err_flag(err_flag),
  .cpu_ptr(cpu_ptr), .eng_ptr(eng_ptr)
);

// File: tb/smb_blkbuf_tb.sv
module smb_blkbuf_tb;
  localparam int DEPTH = 32;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] reg_addr = '0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic       eng_start, eng_wr_mode;
  logic [7:0] eng_count, eng_tx_byte;
  logic       eng_tx_take = 1'b0, eng_rx_valid = 1'b0, eng_done = 1'b0, eng_err = 1'b0;
  logic [7:0] eng_rx_byte = '0, eng_rx_count = '0;

  always #10 clk = ~clk;

  smb_blkbuf u_dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .eng_start(eng_start),
    .eng_wr_mode(eng_wr_mode), .eng_count(eng_count), .eng_tx_byte(eng_tx_byte),
    .eng_tx_take(eng_tx_take), .eng_rx_valid(eng_rx_valid), .eng_rx_byte(eng_rx_byte),
    .eng_done(eng_done), .eng_err(eng_err), .eng_rx_count(eng_rx_count)
  );

  // behavioural reference state
  logic [7:0] m_mem [DEPTH];
  int         m_cpu = 0, m_eng = 0;
  bit         m_busy = 0, m_done = 0, m_err = 0, m_mode = 0, m_start = 0;
  logic [7:0] m_cnt = '0;

  int  vectors = 0, miscompares = 0;
  bit  finished = 0;

  function automatic logic [7:0] m_read(input logic [1:0] a);
    case (a)
      2'd0:    return {5'b0, m_err, m_done, m_busy};
      2'd1:    return {7'b0, m_mode};
      2'd2:    return m_cnt;
      default: return m_mem[m_cpu];
    endcase
  endfunction

  task automatic cmp(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic cyc(input logic w, input logic r, input logic [1:0] a, input logic [7:0] d,
                     input logic tk, input logic rv, input logic [7:0] rb,
                     input logic dn, input logic er, input logic [7:0] rc, input string tag);
    bit ok;
    reg_wr = w; reg_rd = r; reg_addr = a; reg_wdata = d;
    eng_tx_take = tk; eng_rx_valid = rv; eng_rx_byte = rb;
    eng_done = dn; eng_err = er; eng_rx_count = rc;
    #1;
    cmp(tag, "reg_rdata", reg_rdata, m_read(a));
    @(posedge clk);
    ok = w && a == 2'd1 && d[6] && !m_busy && !m_done && !m_err;
    if (w && a == 2'd3 && !m_busy) m_mem[m_cpu] = d;
    if (m_busy && rv) m_mem[m_eng] = rb;
    if (ok) m_eng = 0;
    else if (m_busy && (tk || rv)) m_eng = (m_eng + 1) % DEPTH;
    if (r && a == 2'd1) m_cpu = 0;
    else if ((r || w) && a == 2'd3) m_cpu = (m_cpu + 1) % DEPTH;
    if (m_busy && dn && !m_mode) m_cnt = rc;
    else if (w && a == 2'd2) m_cnt = d;
    if (w && a == 2'd0 && d[1]) m_done = 0;
    if (w && a == 2'd0 && d[2]) m_err = 0;
    if (m_busy && dn) begin
      if (er) m_err = 1; else m_done = 1;
    end
    if (w && a == 2'd1 && !m_busy) m_mode = d[0];
    if (ok) m_busy = 1;
    else if (m_busy && dn) m_busy = 0;
    m_start = ok;
    @(negedge clk);
    cmp(tag, "eng_start", {7'b0, eng_start}, {7'b0, m_start});
    cmp(tag, "eng_wr_mode", {7'b0, eng_wr_mode}, {7'b0, m_mode});
    cmp(tag, "eng_count", eng_count, m_cnt);
    cmp(tag, "eng_tx_byte", eng_tx_byte, m_mem[m_eng]);
  endtask

  task automatic rd(input logic [1:0] a, input string tag);
    cyc(1'b0, 1'b1, a, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00, tag);
  endtask
  task automatic wr(input logic [1:0] a, input logic [7:0] d, input string tag);
    cyc(1'b1, 1'b0, a, d, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00, tag);
  endtask
  task automatic eng(input logic tk, input logic rv, input logic [7:0] rb,
                     input logic dn, input logic er, input logic [7:0] rc, input string tag);
    cyc(1'b0, 1'b0, 2'd0, 8'h00, tk, rv, rb, dn, er, rc, tag);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) m_mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(2'd0, "R1"); rd(2'd1, "R1"); rd(2'd2, "R1"); rd(2'd3, "R1");
    // R12 count register
    wr(2'd2, 8'd5, "R12"); rd(2'd2, "R12");
    // R2 rewind, R3 fill with wrap (33rd write lands on entry 0)
    rd(2'd1, "R2");
    for (int i = 0; i < DEPTH + 1; i++) wr(2'd3, 8'h10 + 8'(i), "R3");
    rd(2'd3, "R3");
    rd(2'd1, "R2");
    for (int i = 0; i < DEPTH; i++) rd(2'd3, "R3");
    // R5 start block write
    wr(2'd1, 8'h41, "R5");
    rd(2'd0, "R5");
    // R6 engine fetch from entry 0
    for (int i = 0; i < 5; i++) eng(1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00, "R6");
    // R9 completion, R10 write mode keeps count
    eng(1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 8'd9, "R9");
    rd(2'd0, "R9"); rd(2'd2, "R10");
    // R7 start refused while done set
    wr(2'd1, 8'h40, "R7"); rd(2'd0, "R7");
    // R4 write-one clear
    wr(2'd0, 8'h02, "R4"); rd(2'd0, "R4");
    // block read: R5 start in read mode
    wr(2'd1, 8'h40, "R5");
    rd(2'd1, "R2");
    wr(2'd3, 8'hEE, "R11");
    wr(2'd1, 8'h41, "R7");
    rd(2'd1, "R5");
    eng(1'b0, 1'b1, 8'hA1, 1'b0, 1'b0, 8'h00, "R8");
    eng(1'b0, 1'b1, 8'hA2, 1'b0, 1'b0, 8'h00, "R8");
    eng(1'b0, 1'b1, 8'hA3, 1'b0, 1'b0, 8'h00, "R8");
    eng(1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 8'd3, "R10");
    rd(2'd2, "R10");
    rd(2'd1, "R2");
    for (int i = 0; i < 4; i++) rd(2'd3, "R11");
    // error completion, then clear colliding with a fresh completion (R4)
    wr(2'd0, 8'h02, "R4");
    wr(2'd1, 8'h40, "R5");
    eng(1'b0, 1'b0, 8'h00, 1'b1, 1'b1, 8'd0, "R9");
    rd(2'd0, "R9"); rd(2'd2, "R10");
    wr(2'd1, 8'h40, "R7");
    wr(2'd0, 8'h04, "R4");
    wr(2'd1, 8'h40, "R5");
    cyc(1'b1, 1'b0, 2'd0, 8'h06, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 8'd7, "R4");
    rd(2'd0, "R4");
    wr(2'd0, 8'h06, "R4"); rd(2'd0, "R4");
    summary();
  end
endmodule